// File: doc/BRIEF.md
# Clause-Locked Constant Cache

This block is a per-SIMD store of 128-bit shader constants for one clause of VLIW instructions. When the scheduler opens a clause, it states up to four constant-buffer line addresses. The cache fetches every line it lacks from an external memory, one constant per beat. The lines then stay pinned in numbered slots until the clause closes. The ALU side reads a constant by giving a (slot, element) pair. Slot reads are held off until every named line is resident.

The same storage array holds a separate bank of 256 legacy constant registers. These are written directly and can be read at any time. Line slots keep their contents after a clause closes. A later clause that names the same line in the same slot uses it again without a refill.

Top module: `clause_const_cache`

## Requirements
- R1: A clause start with count N (0 to 4) and line addresses L0..L3 loads each named line Lk into slot k. A refill takes 16 beats. While a refill is pending, `rf_req_o` is high and `rf_line_o` carries the line address, held steady until a beat is accepted. Beats arrive on `rf_valid_i` in element order 0 to 15. Pending slots fill in ascending slot order.
- R2: `rd_ready_o` is high only while a clause is open, all of its named lines are resident and no refill is pending. It rises in the cycle after the last beat. When no refill is needed, it rises in the cycle after the start.
- R3: When `rd_ready_o` is high, a slot read (`rd_legacy_i`=0) of element e in a named slot k sets `rd_valid_o` one cycle later. `rd_data_o` then carries element e of line Lk.
- R4: A slot read gives no `rd_valid_o` in two cases: `rd_ready_o` is low, or the slot index is not below the clause's line count.
- R5: No refill beats are fetched for slot k when the new clause names, for slot k, the line that slot k already holds in full.
- R6: While a clause is open, further clause starts are ignored. Lines, readiness and refill activity are unchanged.
- R7: `end_i` closes the clause when `rd_ready_o` is high, and `rd_ready_o` is low in the next cycle. `end_i` has no effect while a refill is pending.
- R8: The 256-entry legacy bank is written through `lg_we_i`/`lg_addr_i`/`lg_data_i`. A legacy read (`rd_legacy_i`=1, index on `rd_reg_i`) is served one cycle later in every state. Legacy entries and line slots do not overwrite each other.
- R9: One read is accepted per cycle, back to back. Each returns the full 128-bit value, and every `rd_valid_o` follows a read request in the cycle before.
- R10: After reset `rd_ready_o`, `rd_valid_o` and `rf_req_o` are low and no slot holds a line, so the first clause refills every line it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Open a clause |
| start_cnt_i | input | 3 | Number of named lines, 0 to 4 |
| start_lines_i | input | 48 | Line address for slot k at bits [12k+11:12k] |
| end_i | input | 1 | Close the clause |
| rf_req_o | output | 1 | Refill pending |
| rf_line_o | output | 12 | Line address being refilled |
| rf_valid_i | input | 1 | Refill beat present |
| rf_data_i | input | 128 | Refill beat data |
| lg_we_i | input | 1 | Legacy register write |
| lg_addr_i | input | 8 | Legacy register index for write |
| lg_data_i | input | 128 | Legacy register write data |
| rd_req_i | input | 1 | Read request |
| rd_legacy_i | input | 1 | 1 reads the legacy bank, 0 reads a line slot |
| rd_slot_i | input | 2 | Line slot for a slot read |
| rd_elem_i | input | 4 | Element within the line |
| rd_reg_i | input | 8 | Legacy register index for a read |
| rd_ready_o | output | 1 | All named lines resident |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 128 | Read data |

## Verification
The assertions check the cycle-level rules on every cycle:
- stalled slot reads never return data;
- legacy reads always return data;
- readiness and refill activity are mutually exclusive;
- an open, ready clause stays ready until it is ended, and closes on an accepted end;
- the refill line address is held while a refill waits for a beat.

Only the bench scenarios can show the following:
- the data contents;
- the order in which lines are fetched;
- that a reused line costs no beats;
- that legacy and slot storage stay apart.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  localparam int unsigned CCC_SLOTS     = 4;
  localparam int unsigned CCC_ELEMS     = 16;
  localparam int unsigned CCC_DATA_W    = 128;
  localparam int unsigned CCC_LINE_W    = 12;
  localparam int unsigned CCC_LEG_DEPTH = 256;
endpackage

// File: rtl/ccc_fill_ctrl.sv
module ccc_fill_ctrl #(
  parameter int unsigned SLOTS  = ccc_pkg::CCC_SLOTS,
  parameter int unsigned ELEMS  = ccc_pkg::CCC_ELEMS,
  parameter int unsigned LINE_W = ccc_pkg::CCC_LINE_W,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned ELEM_W = $clog2(ELEMS),
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [CNT_W-1:0]        start_cnt_i,
  input  logic [SLOTS*LINE_W-1:0] start_lines_i,
  input  logic                    end_i,
  output logic                    rf_req_o,
  output logic [LINE_W-1:0]       rf_line_o,
  input  logic                    rf_valid_i,
  output logic                    wr_en_o,
  output logic [SLOT_W-1:0]       wr_slot_o,
  output logic [ELEM_W-1:0]       wr_elem_o,
  output logic                    ready_o,
  output logic [CNT_W-1:0]        named_cnt_o
);
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ELEM_W-1:0] beat_q;
  logic [SLOTS-1:0]  need_w;
  logic [LINE_W-1:0] tag_w [SLOTS];
  logic [SLOT_W-1:0] cur;

  // lowest pending slot fills first
  always_comb begin
    cur = '0;
    for (int k = SLOTS - 1; k >= 0; k--)
      if (need_w[k]) cur = SLOT_W'(k);
  end

  logic start_ok, ready, beat_ok, beat_last;
  assign start_ok  = start_i && !active_q;
  assign ready     = active_q && (need_w == '0);
  assign beat_ok   = rf_valid_i && (need_w != '0);
  assign beat_last = beat_ok && (beat_q == ELEM_W'(ELEMS - 1));

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [LINE_W-1:0] tag_q;
    logic              res_q, need_q;
    logic [LINE_W-1:0] line_k;
    logic              named_k, hit_k;
    assign line_k  = start_lines_i[k*LINE_W +: LINE_W];
    assign named_k = CNT_W'(k) < start_cnt_i;
    assign hit_k   = res_q && (tag_q == line_k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q  <= '0;
        res_q  <= 1'b0;
        need_q <= 1'b0;
      end else if (start_ok && named_k) begin
        tag_q  <= line_k;
        res_q  <= hit_k;
        need_q <= !hit_k;
      end else if (beat_last && cur == SLOT_W'(k)) begin
        res_q  <= 1'b1;
        need_q <= 1'b0;
      end
    end
    assign need_w[k] = need_q;
    assign tag_w[k]  = tag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_ok) begin
      active_q <= 1'b1;
      cnt_q    <= start_cnt_i;
    end else if (end_i && ready) begin
      active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        beat_q <= '0;
    else if (beat_last) beat_q <= '0;
    else if (beat_ok)   beat_q <= beat_q + 1'b1;
  end

  assign rf_req_o    = need_w != '0;
  assign rf_line_o   = tag_w[cur];
  assign wr_en_o     = beat_ok;
  assign wr_slot_o   = cur;
  assign wr_elem_o   = beat_q;
  assign ready_o     = ready;
  assign named_cnt_o = cnt_q;
endmodule

// File: rtl/ccc_store.sv
module ccc_store #(
  parameter int unsigned SLOTS     = ccc_pkg::CCC_SLOTS,
  parameter int unsigned ELEMS     = ccc_pkg::CCC_ELEMS,
  parameter int unsigned DATA_W    = ccc_pkg::CCC_DATA_W,
  parameter int unsigned LEG_DEPTH = ccc_pkg::CCC_LEG_DEPTH,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned ELEM_W   = $clog2(ELEMS),
  localparam int unsigned LEG_W    = $clog2(LEG_DEPTH),
  localparam int unsigned LINE_ENT = SLOTS * ELEMS,
  localparam int unsigned DEPTH    = LINE_ENT + LEG_DEPTH,
  localparam int unsigned ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_we_i,
  input  logic [SLOT_W-1:0] fill_slot_i,
  input  logic [ELEM_W-1:0] fill_elem_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              leg_we_i,
  input  logic [LEG_W-1:0]  leg_addr_i,
  input  logic [DATA_W-1:0] leg_data_i,
  input  logic              rd_en_i,
  input  logic              rd_legacy_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [ELEM_W-1:0] rd_elem_i,
  input  logic [LEG_W-1:0]  rd_reg_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] fill_addr, leg_addr, rd_addr;

  // lines occupy the low region, legacy registers sit above them
  assign fill_addr = ADDR_W'(fill_slot_i) * ADDR_W'(ELEMS) + ADDR_W'(fill_elem_i);
  assign leg_addr  = ADDR_W'(LINE_ENT) + ADDR_W'(leg_addr_i);
  assign rd_addr   = rd_legacy_i ? ADDR_W'(LINE_ENT) + ADDR_W'(rd_reg_i)
                                 : ADDR_W'(rd_slot_i) * ADDR_W'(ELEMS) + ADDR_W'(rd_elem_i);

  always_ff @(posedge clk_i) begin
    if (fill_we_i) mem_q[fill_addr] <= fill_data_i;
    if (leg_we_i)  mem_q[leg_addr]  <= leg_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= mem_q[rd_addr];
  end
endmodule

// File: rtl/clause_const_cache.sv
module clause_const_cache #(
  parameter int unsigned SLOTS     = ccc_pkg::CCC_SLOTS,
  parameter int unsigned ELEMS     = ccc_pkg::CCC_ELEMS,
  parameter int unsigned DATA_W    = ccc_pkg::CCC_DATA_W,
  parameter int unsigned LINE_W    = ccc_pkg::CCC_LINE_W,
  parameter int unsigned LEG_DEPTH = ccc_pkg::CCC_LEG_DEPTH,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned ELEM_W   = $clog2(ELEMS),
  localparam int unsigned LEG_W    = $clog2(LEG_DEPTH),
  localparam int unsigned CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [CNT_W-1:0]        start_cnt_i,
  input  logic [SLOTS*LINE_W-1:0] start_lines_i,
  input  logic                    end_i,
  output logic                    rf_req_o,
  output logic [LINE_W-1:0]       rf_line_o,
  input  logic                    rf_valid_i,
  input  logic [DATA_W-1:0]       rf_data_i,
  input  logic                    lg_we_i,
  input  logic [LEG_W-1:0]        lg_addr_i,
  input  logic [DATA_W-1:0]       lg_data_i,
  input  logic                    rd_req_i,
  input  logic                    rd_legacy_i,
  input  logic [SLOT_W-1:0]       rd_slot_i,
  input  logic [ELEM_W-1:0]       rd_elem_i,
  input  logic [LEG_W-1:0]        rd_reg_i,
  output logic                    rd_ready_o,
  output logic                    rd_valid_o,
  output logic [DATA_W-1:0]       rd_data_o
);
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [ELEM_W-1:0] wr_elem;
  logic              ready;
  logic [CNT_W-1:0]  named_cnt;
  logic              rd_fire;

  ccc_fill_ctrl #(.SLOTS(SLOTS), .ELEMS(ELEMS), .LINE_W(LINE_W)) u_fill (
    .clk_i, .rst_ni, .start_i, .start_cnt_i, .start_lines_i, .end_i,
    .rf_req_o, .rf_line_o, .rf_valid_i,
    .wr_en_o(wr_en), .wr_slot_o(wr_slot), .wr_elem_o(wr_elem),
    .ready_o(ready), .named_cnt_o(named_cnt)
  );

  // slot reads wait for residency and must name a slot of this clause
  assign rd_fire = rd_req_i &&
                   (rd_legacy_i || (ready && (CNT_W'(rd_slot_i) < named_cnt)));

  ccc_store #(.SLOTS(SLOTS), .ELEMS(ELEMS), .DATA_W(DATA_W), .LEG_DEPTH(LEG_DEPTH)) u_store (
    .clk_i, .rst_ni,
    .fill_we_i(wr_en), .fill_slot_i(wr_slot), .fill_elem_i(wr_elem), .fill_data_i(rf_data_i),
    .leg_we_i(lg_we_i), .leg_addr_i(lg_addr_i), .leg_data_i(lg_data_i),
    .rd_en_i(rd_fire), .rd_legacy_i, .rd_slot_i, .rd_elem_i, .rd_reg_i,
    .rd_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_o <= 1'b0;
    else         rd_valid_o <= rd_fire;
  end

  assign rd_ready_o = ready;
endmodule

// File: rtl/ccc_checker.sv
module ccc_checker #(
  parameter int unsigned LINE_W = ccc_pkg::CCC_LINE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              end_i,
  input logic              rf_req_o,
  input logic [LINE_W-1:0] rf_line_o,
  input logic              rf_valid_i,
  input logic              rd_req_i,
  input logic              rd_legacy_i,
  input logic              rd_ready_o,
  input logic              rd_valid_o
);
  AST_LINE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_req_o && !rf_valid_i) |=> $stable(rf_line_o)); // R1
  AST_READY_NO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o |-> !rf_req_o); // R2
  AST_STALL_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_legacy_i && !rd_ready_o) |=> !rd_valid_o); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ready_o && !end_i) |=> rd_ready_o); // R6
  AST_END_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ready_o && end_i) |=> !rd_ready_o); // R7
  AST_LEGACY_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && rd_legacy_i) |=> rd_valid_o); // R8
  AST_VALID_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_req_i)); // R9
endmodule

bind clause_const_cache ccc_checker #(.LINE_W(LINE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .end_i(end_i), .rf_req_o(rf_req_o),
  .rf_line_o(rf_line_o), .rf_valid_i(rf_valid_i), .rd_req_i(rd_req_i),
  .rd_legacy_i(rd_legacy_i), .rd_ready_o(rd_ready_o), .rd_valid_o(rd_valid_o)
);

// File: tb/clause_const_cache_tb.sv
module clause_const_cache_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic         start_i = 0, end_i = 0;
  logic [2:0]   start_cnt_i = 0;
  logic [47:0]  start_lines_i = 0;
  logic         rf_req_o, rf_valid_i = 0;
  logic [11:0]  rf_line_o;
  logic [127:0] rf_data_i = 0;
  logic         lg_we_i = 0;
  logic [7:0]   lg_addr_i = 0;
  logic [127:0] lg_data_i = 0;
  logic         rd_req_i = 0, rd_legacy_i = 0;
  logic [1:0]   rd_slot_i = 0;
  logic [3:0]   rd_elem_i = 0;
  logic [7:0]   rd_reg_i = 0;
  logic         rd_ready_o, rd_valid_o;
  logic [127:0] rd_data_o;

  clause_const_cache u_dut (.clk_i(clk), .*);

  int n_chk = 0, n_fail = 0;
  int beats = 0, log_n = 0;
  int line_log [16];
  logic [3:0] bt = 0;
  logic gap = 1'b1, tgl = 1'b0;

  function automatic logic [127:0] line_val(int l, int e);
    return {16'hC0DE, 8'(l), 8'(e), 32'(l * 37 + e), ~32'(l), 32'(e * 1000 + l)};
  endfunction
  function automatic logic [127:0] leg_val(int r);
    return {32'hA5A50000 | 32'(r), ~32'(r), 32'(r * r), 32'(r + 7)};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory model: beat e of line L is line_val(L,e)
  always @(negedge clk) begin
    tgl <= ~tgl;
    rf_valid_i <= rf_req_o && (!gap || tgl);
    rf_data_i  <= line_val(int'(rf_line_o), int'(bt));
  end
  always @(posedge clk) if (rst_ni && rf_valid_i) begin
    if (bt == 0 && log_n < 16) begin line_log[log_n] = int'(rf_line_o); log_n++; end
    bt <= bt + 1'b1;
    beats++;
  end

  task automatic open_clause(int cnt, int l0, int l1, int l2, int l3);
    @(negedge clk);
    start_i = 1; start_cnt_i = 3'(cnt);
    start_lines_i = {12'(l3), 12'(l2), 12'(l1), 12'(l0)};
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic close_clause();
    @(negedge clk); end_i = 1;
    @(negedge clk); end_i = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !rd_ready_o; i++) @(negedge clk);
  endtask

  // one read issued at a negedge, result checked at the next
  task automatic rd_one(string req, bit leg, int slot, int idx, bit exp_v, logic [127:0] exp_d);
    rd_req_i = 1; rd_legacy_i = leg; rd_slot_i = 2'(slot);
    rd_elem_i = 4'(idx); rd_reg_i = 8'(idx);
    @(negedge clk);
    chk(req, 128'(rd_valid_o), 128'(exp_v));
    if (exp_v) chk(req, rd_data_o, exp_d);
  endtask

  task automatic sweep_lines(string req, int l0, int l1, int l2, int l3);
    int ls [4];
    ls = '{l0, l1, l2, l3};
    @(negedge clk);
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 16; e++)
        rd_one(req, 0, s, e, 1, line_val(ls[s], e));
    rd_req_i = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready", 128'(rd_ready_o), 0);
    chk("R10 valid", 128'(rd_valid_o), 0);
    chk("R10 rfreq", 128'(rf_req_o), 0);
    rst_ni = 1;

    // clause A, throttled refill
    open_clause(4, 3, 7, 12, 20);
    chk("R2 not ready after start", 128'(rd_ready_o), 0);
    chk("R1 req", 128'(rf_req_o), 1);
    chk("R1 first line", 128'(rf_line_o), 3);
    rd_one("R4 stalled read", 0, 0, 0, 0, 0);
    rd_req_i = 0;
    wait_ready();
    chk("R10 all refilled", 128'(beats), 64);
    chk("R1 order0", 128'(line_log[0]), 3);
    chk("R1 order1", 128'(line_log[1]), 7);
    chk("R1 order2", 128'(line_log[2]), 12);
    chk("R1 order3", 128'(line_log[3]), 20);
    chk("R2 ready", 128'(rd_ready_o), 1);
    sweep_lines("R3 R9 sweep A", 3, 7, 12, 20);

    // R6 second start while open
    b0 = beats;
    open_clause(4, 1, 2, 5, 6);
    repeat (40) @(negedge clk);
    chk("R6 no refill", 128'(beats - b0), 0);
    chk("R6 still ready", 128'(rd_ready_o), 1);
    rd_one("R6 lines kept", 0, 1, 5, 1, line_val(7, 5));
    rd_req_i = 0;

    // R8 legacy bank write and sweep
    for (int r = 0; r < 256; r++) begin
      lg_we_i = 1; lg_addr_i = 8'(r); lg_data_i = leg_val(r);
      @(negedge clk);
    end
    lg_we_i = 0;
    for (int r = 0; r < 256; r++) rd_one("R8 R9 legacy sweep", 1, 0, r, 1, leg_val(r));
    rd_req_i = 0;
    rd_one("R8 slots untouched", 0, 3, 15, 1, line_val(20, 15));
    rd_req_i = 0;

    // R7 end closes
    close_clause();
    chk("R7 closed", 128'(rd_ready_o), 0);
    rd_one("R4 read while closed", 0, 2, 3, 0, 0);
    rd_one("R8 legacy while closed", 1, 0, 77, 1, leg_val(77));
    rd_req_i = 0;

    // clause B reuses slots 0 and 2; end during refill is ignored
    b0 = beats; log_n = 0;
    open_clause(4, 3, 9, 12, 21);
    @(negedge clk); end_i = 1;
    @(negedge clk); end_i = 0;
    wait_ready();
    chk("R7 end ignored in refill", 128'(rd_ready_o), 1);
    chk("R5 reuse beats", 128'(beats - b0), 32);
    chk("R1 B order0", 128'(line_log[0]), 9);
    chk("R1 B order1", 128'(line_log[1]), 21);
    sweep_lines("R3 R5 sweep B", 3, 9, 12, 21);
    rd_one("R8 legacy after refill", 1, 0, 200, 1, leg_val(200));
    rd_req_i = 0;
    close_clause();

    // clause C, two lines, unthrottled
    gap = 0; b0 = beats;
    open_clause(2, 40, 41, 0, 0);
    wait_ready();
    chk("R1 two lines", 128'(beats - b0), 32);
    rd_one("R4 unnamed slot", 0, 3, 0, 0, 0);
    rd_one("R4 unnamed slot2", 0, 2, 4, 0, 0);
    rd_one("R3 slot1", 0, 1, 15, 1, line_val(41, 15));
    rd_one("R3 slot0", 0, 0, 0, 1, line_val(40, 0));
    rd_req_i = 0;
    close_clause();

    // clause D names no line
    b0 = beats;
    open_clause(0, 0, 0, 0, 0);
    chk("R2 empty clause ready", 128'(rd_ready_o), 1);
    chk("R2 no beats", 128'(beats - b0), 0);
    rd_one("R4 slot in empty clause", 0, 0, 0, 0, 0);
    rd_req_i = 0;
    close_clause();
    chk("R7 closed D", 128'(rd_ready_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule